// File: doc/BRIEF.md
# Instruction Fetch Trace Decoder

This block sits beside a processor as a passive trace monitor. The processor marks the bus cycles that feed its instruction pipeline with a single active-low indicator, and it uses the pulse width of that indicator to carry two meanings. A one-clock assertion means that the word on the data bus is an ordinary prefetch. A two-clock assertion means that the pipeline was emptied and that this word is the first one of the refill. The decoder finds the start of every bus cycle from the address strobe, or from the data strobe when a show-cycle flag is raised. It samples the indicator on two consecutive rising edges and reports the result as a single-cycle event together with the captured word.

On a fast two-clock bus, a flush followed at once by another prefetch shows up as a single three-clock assertion. Because each bus cycle is sampled separately, the first two clocks decode as the flush and the third decodes as the prefetch of the next cycle. The decoder also keeps a three-stage model of the pipeline. Stage A is the raw input buffer, stage B is the word being decoded, and stage C is the word in residual decode. The model is driven by the decoded events and by a separate pipe-advance strobe, and it raises a sticky error when a prefetch arrives with nowhere to go.

Top module: `fetch_trace_decoder`

## Requirements
- R1: A synchronous active-high reset clears every stage valid flag, the error flag, both event outputs, the sampling state and all data outputs. The decoder then treats the strobe as if it had been high at the previous edge.
- R2: A bus cycle starts at a rising edge where the selected strobe is low and was high at the previous edge. That edge and the one after it are the two sampling edges. The selected strobe is `ds_n` when `show_cyc` is 1 and `as_n` when it is 0, and the unselected strobe has no effect.
- R3: If exactly one of the two samples finds `fetch_n` low, `fetch_evt` is 1 for the single cycle after the second sampling edge. `evt_data` then holds the `data_in` value from the second sampling edge.
- R4: If both samples find `fetch_n` low, `flush_evt` is 1 (and `fetch_evt` is 0) with the same timing, and `evt_data` is captured as in R3.
- R5: If neither sample finds `fetch_n` low, no event is produced. `fetch_n` has no effect at edges that are not sampling edges.
- R6: On a two-clock bus (strobe low for one clock and high for the next), `fetch_n` held low for three clocks produces `flush_evt` for the first cycle and then `fetch_evt` for the next cycle, two clocks later.
- R7: A flush clears the valid flags of stages B and C and writes the captured word into stage A as valid. A pipe advance at the same edge is ignored.
- R8: A prefetch writes the captured word into stage A as valid when stage A is empty, or when `pipe_adv` is 1 at the same edge.
- R9: `pipe_adv` at an edge without a flush or an overflow moves stage B (valid flag and word) into C and stage A into B, and it leaves stage A invalid unless R8 refills it.
- R10: A prefetch while stage A is valid and `pipe_adv` is 0 sets `ovf_err`, which stays set until reset, and leaves all three stages unchanged.
- R11: `fetch_evt` and `flush_evt` are never 1 together and never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_n | input | 1 | Active-low pulse-width-coded fetch indicator |
| as_n | input | 1 | Active-low address strobe |
| ds_n | input | 1 | Active-low data strobe, used during show cycles |
| show_cyc | input | 1 | 1 selects ds_n as the cycle strobe |
| pipe_adv | input | 1 | Pipeline advance strobe |
| data_in | input | DW | Bus data |
| fetch_evt | output | 1 | One-cycle prefetch event |
| flush_evt | output | 1 | One-cycle flush-plus-fetch event |
| evt_data | output | DW | Word captured with the last event |
| stg_a_vld | output | 1 | Stage A valid |
| stg_a_dat | output | DW | Stage A word |
| stg_b_vld | output | 1 | Stage B valid |
| stg_b_dat | output | DW | Stage B word |
| stg_c_vld | output | 1 | Stage C valid |
| stg_c_dat | output | DW | Stage C word |
| ovf_err | output | 1 | Sticky prefetch overflow error |

## Verification
The hardest case to reach is the merged three-clock assertion on a two-clock bus. To produce it, the strobe has to fall again on the edge right after the second sample of a flush while `fetch_n` is still low. The stimulus builds this case from back-to-back two-clock bus cycles, with patterns low-low followed by low-high. A pipe advance is placed on the second of those cycles, so the prefetch that follows the flush is accepted instead of raising an overflow. The overflow itself is reached by sending two prefetches with no advance between them, and a random phase mixes all of these patterns with show cycles, slow bus cycles and occasional resets.

// File: rtl/fetch_trace_decoder.sv
module fetch_trace_decoder #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_n,
  input  logic          as_n,
  input  logic          ds_n,
  input  logic          show_cyc,
  input  logic          pipe_adv,
  input  logic [DW-1:0] data_in,
  output logic          fetch_evt,
  output logic          flush_evt,
  output logic [DW-1:0] evt_data,
  output logic          stg_a_vld,
  output logic [DW-1:0] stg_a_dat,
  output logic          stg_b_vld,
  output logic [DW-1:0] stg_b_dat,
  output logic          stg_c_vld,
  output logic [DW-1:0] stg_c_dat,
  output logic          ovf_err
);

  logic strb_q, phase, s1;

  wire strb      = show_cyc ? ds_n : as_n;
  wire start     = strb_q & ~strb & ~phase;
  wire s2        = ~fetch_n;
  wire dec_flush = phase & s1 & s2;
  wire dec_fetch = phase & (s1 ^ s2);
  wire ovf_hit   = dec_fetch & stg_a_vld & ~pipe_adv;
  wire accept    = dec_fetch & ~ovf_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q    <= 1'b1;
      phase     <= 1'b0;
      s1        <= 1'b0;
      fetch_evt <= 1'b0;
      flush_evt <= 1'b0;
      evt_data  <= '0;
    end else begin
      strb_q    <= strb;
      fetch_evt <= dec_fetch;
      flush_evt <= dec_flush;
      if (start) begin
        phase <= 1'b1;
        s1    <= ~fetch_n;
      end else begin
        phase <= 1'b0;
      end
      if (phase) evt_data <= data_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_a_vld <= 1'b0;
      stg_b_vld <= 1'b0;
      stg_c_vld <= 1'b0;
      stg_a_dat <= '0;
      stg_b_dat <= '0;
      stg_c_dat <= '0;
      ovf_err   <= 1'b0;
    end else if (dec_flush) begin
      stg_a_vld <= 1'b1;
      stg_a_dat <= data_in;
      stg_b_vld <= 1'b0;
      stg_c_vld <= 1'b0;
    end else if (ovf_hit) begin
      ovf_err <= 1'b1;
    end else begin
      if (pipe_adv) begin
        stg_c_vld <= stg_b_vld;
        stg_c_dat <= stg_b_dat;
        stg_b_vld <= stg_a_vld;
        stg_b_dat <= stg_a_dat;
        stg_a_vld <= 1'b0;
      end
      if (accept) begin
        stg_a_vld <= 1'b1;
        stg_a_dat <= data_in;
      end
    end
  end

  // R11
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_evt, flush_evt}));

  // R11
  evt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_evt || flush_evt) |=> !(fetch_evt || flush_evt));

  // R7
  flush_model_chk: assert property (@(posedge clk) disable iff (rst)
    flush_evt |-> (stg_a_vld && !stg_b_vld && !stg_c_vld && stg_a_dat == evt_data));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  // R8
  fetch_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_evt |-> stg_a_vld);

endmodule

// File: tb/fetch_trace_decoder_tb.sv
module fetch_trace_decoder_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic d_rst = 1'b1, d_fn = 1'b1, d_as = 1'b1, d_ds = 1'b1, d_sh = 1'b0, d_adv = 1'b0;
  logic [DW-1:0] d_dat = '0;

  logic fetch_evt, flush_evt, stg_a_vld, stg_b_vld, stg_c_vld, ovf_err;
  logic [DW-1:0] evt_data, stg_a_dat, stg_b_dat, stg_c_dat;

  fetch_trace_decoder #(.DW(DW)) u_dut (
    .clk(clk), .rst(d_rst), .fetch_n(d_fn), .as_n(d_as), .ds_n(d_ds),
    .show_cyc(d_sh), .pipe_adv(d_adv), .data_in(d_dat),
    .fetch_evt(fetch_evt), .flush_evt(flush_evt), .evt_data(evt_data),
    .stg_a_vld(stg_a_vld), .stg_a_dat(stg_a_dat),
    .stg_b_vld(stg_b_vld), .stg_b_dat(stg_b_dat),
    .stg_c_vld(stg_c_vld), .stg_c_dat(stg_c_dat),
    .ovf_err(ovf_err)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  bit r_prev = 1, r_in_cycle = 0, r_first = 0;
  bit r_fe = 0, r_fl = 0, r_ovf = 0;
  int r_evd = 0;
  bit r_v[3];
  int r_d[3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ref_update();
    bit s, second, fl, fe;
    if (d_rst) begin
      r_prev = 1; r_in_cycle = 0; r_first = 0; r_fe = 0; r_fl = 0; r_ovf = 0; r_evd = 0;
      for (int i = 0; i < 3; i++) begin r_v[i] = 0; r_d[i] = 0; end
      return;
    end
    s = d_sh ? d_ds : d_as;
    fl = 0; fe = 0;
    if (r_in_cycle) begin
      second = !d_fn;
      fl = r_first && second;
      fe = (r_first != second);
      r_evd = d_dat;
      r_in_cycle = 0;
    end else if (r_prev && !s) begin
      r_in_cycle = 1;
      r_first = !d_fn;
    end
    r_prev = s;
    r_fe = fe; r_fl = fl;
    if (fl) begin
      r_v[0] = 1; r_d[0] = d_dat; r_v[1] = 0; r_v[2] = 0;
    end else if (fe && r_v[0] && !d_adv) begin
      r_ovf = 1;
    end else begin
      if (d_adv) begin
        r_v[2] = r_v[1]; r_d[2] = r_d[1];
        r_v[1] = r_v[0]; r_d[1] = r_d[0];
        r_v[0] = 0;
      end
      if (fe) begin r_v[0] = 1; r_d[0] = d_dat; end
    end
  endtask

  task automatic compare();
    chk(fetch_evt == r_fe, "R3 fetch_evt", fetch_evt, r_fe);
    chk(flush_evt == r_fl, "R4 flush_evt", flush_evt, r_fl);
    chk(evt_data == DW'(r_evd), "R3 evt_data", evt_data, r_evd);
    chk(stg_a_vld == r_v[0], "R8 stg_a_vld", stg_a_vld, r_v[0]);
    if (r_v[0]) chk(stg_a_dat == DW'(r_d[0]), "R8 stg_a_dat", stg_a_dat, r_d[0]);
    chk(stg_b_vld == r_v[1], "R9 stg_b_vld", stg_b_vld, r_v[1]);
    if (r_v[1]) chk(stg_b_dat == DW'(r_d[1]), "R9 stg_b_dat", stg_b_dat, r_d[1]);
    chk(stg_c_vld == r_v[2], "R9 stg_c_vld", stg_c_vld, r_v[2]);
    if (r_v[2]) chk(stg_c_dat == DW'(r_d[2]), "R9 stg_c_dat", stg_c_dat, r_d[2]);
    chk(ovf_err == r_ovf, "R10 ovf_err", ovf_err, r_ovf);
  endtask

  task automatic tick();
    @(posedge clk);
    ref_update();
    @(negedge clk);
    compare();
  endtask

  // two-clock bus cycle; the strobe is low on the first edge only
  task automatic bcyc(input bit sh, input bit f1, input bit f2, input logic [DW-1:0] w, input bit adv);
    d_sh = sh;
    if (sh) begin d_ds = 0; d_as = 1; end else begin d_as = 0; d_ds = 1; end
    d_fn = f1; d_adv = 0; d_dat = $urandom; tick();
    d_as = 1; d_ds = 1; d_fn = f2; d_dat = w; d_adv = adv; tick();
    d_adv = 0;
  endtask

  task automatic idle(input int n, input bit adv);
    for (int i = 0; i < n; i++) begin
      d_as = 1; d_ds = 1; d_fn = 1; d_adv = adv; tick();
    end
    d_adv = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    d_rst = 1; tick(); tick();
    // R1 reset state
    chk(!stg_a_vld && !stg_b_vld && !stg_c_vld && !ovf_err && !fetch_evt && !flush_evt,
        "R1 reset", {stg_a_vld, stg_b_vld, stg_c_vld, ovf_err}, 0);
    d_rst = 0;

    // R5 fetch_n toggling outside any bus cycle
    for (int i = 0; i < 6; i++) begin d_fn = i[0]; d_as = 1; d_ds = 1; tick(); end
    chk(!stg_a_vld && !fetch_evt && !flush_evt, "R5 idle fetch_n", stg_a_vld, 0);

    // R3 single assertion on first sample
    bcyc(0, 0, 1, 16'h1111, 0);
    chk(fetch_evt && evt_data == 16'h1111, "R3 fetch first", evt_data, 16'h1111);
    idle(1, 1);
    // R3 single assertion on second sample, A empty after the advance
    bcyc(0, 1, 0, 16'h2222, 0);
    chk(fetch_evt && stg_a_dat == 16'h2222 && stg_b_dat == 16'h1111, "R3 fetch second", stg_a_dat, 16'h2222);
    // R5 no assertion
    bcyc(0, 1, 1, 16'h3333, 0);
    chk(!fetch_evt && !flush_evt, "R5 no event", {fetch_evt, flush_evt}, 0);

    // R10 overflow: A valid, no advance
    bcyc(0, 0, 1, 16'h4444, 0);
    chk(ovf_err && stg_a_dat == 16'h2222, "R10 overflow", stg_a_dat, 16'h2222);
    idle(2, 0);
    chk(ovf_err, "R10 sticky", ovf_err, 1);

    // R8 fetch with simultaneous advance
    bcyc(0, 1, 0, 16'h5555, 1);
    chk(stg_a_dat == 16'h5555 && stg_b_dat == 16'h2222 && stg_c_dat == 16'h1111, "R8 fetch+adv", stg_a_dat, 16'h5555);

    // R4 R7 flush with simultaneous advance ignored
    bcyc(0, 0, 0, 16'h6666, 1);
    chk(flush_evt && !fetch_evt && stg_a_dat == 16'h6666 && !stg_b_vld && !stg_c_vld, "R7 flush", flush_evt, 1);

    // R6 merged three-clock assertion on a two-clock bus
    d_rst = 1; tick(); d_rst = 0;
    bcyc(0, 0, 0, 16'h7001, 0);
    chk(flush_evt, "R6 merged flush", flush_evt, 1);
    bcyc(0, 0, 1, 16'h7002, 1);
    chk(fetch_evt && stg_a_dat == 16'h7002 && stg_b_dat == 16'h7001 && !ovf_err, "R6 merged fetch", stg_b_dat, 16'h7001);

    // R2 show cycle uses ds_n; as_n pulses ignored while show_cyc is set
    idle(3, 1);
    bcyc(1, 0, 1, 16'h8888, 0);
    chk(fetch_evt && stg_a_dat == 16'h8888, "R2 show strobe", evt_data, 16'h8888);
    idle(1, 1);
    d_sh = 1; d_ds = 1; d_as = 0; d_fn = 0; tick();
    d_as = 1; d_fn = 0; tick(); tick();
    chk(!stg_a_vld && !flush_evt && !fetch_evt, "R2 unselected strobe", stg_a_vld, 0);
    d_sh = 0; d_fn = 1;

    // slow three-clock bus cycles
    for (int i = 0; i < 4; i++) begin
      d_as = 0; d_fn = 0; tick();
      d_fn = (i == 1) ? 1'b0 : 1'b1; d_dat = 16'h9000 + DW'(i); tick();
      d_as = 1; d_fn = 1; d_adv = 1; tick(); d_adv = 0;
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) begin d_rst = 1; tick(); d_rst = 0; end
      else if (k < 4) idle($urandom_range(1, 3), $urandom_range(0, 1));
      else bcyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), DW'($urandom), $urandom_range(0, 1));
    end

    // R1 mid-run reset
    d_rst = 1; tick(); d_rst = 0;
    chk(!stg_a_vld && !ovf_err, "R1 mid-run reset", ovf_err, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule